// File: doc/BRIEF.md
# Dual-Address I2C Memory Slave

This block is the serial front end of a two-space register memory. It watches SCL and SDA with a fast system clock and frames each transaction between START and STOP. It answers on two slave addresses. The first is a fixed address that opens the auxiliary space. The second comes from a configuration register, opens the main space and is live only while its enable bit is set. The block acknowledges bytes by pulling SDA low through an output enable, keeps a memory pointer, and issues one-cycle read and write strobes toward the memory that sits behind it.

A write transaction carries the device byte, one memory-address byte, then data bytes. The data bytes go to consecutive locations inside one 8-byte page; past the end of the page the pointer wraps to the start of that page. A read opens with a repeated START and a device byte whose R/W bit is 1. It streams bytes from the last captured pointer and moves linearly through the space. A busy input makes the block refuse its own address, so a master can poll until the memory is ready.

The controller is one state machine. Its states are IDLE, DEV_ADDR, DEV_ACK, MEM_ADDR, MEM_ACK, WR_DATA, WR_COMMIT, WR_ACK, RD_REQ, RD_FILL, RD_DATA, RD_ACK and IGNORE. A START in any state enters DEV_ADDR, and a STOP in any state enters IDLE. DEV_ADDR goes to DEV_ACK on a hit and to IGNORE otherwise. DEV_ACK leads to MEM_ADDR for a write or to RD_REQ for a read. MEM_ADDR goes to MEM_ACK and then to WR_DATA. The write loop runs WR_DATA → WR_COMMIT → WR_ACK → WR_DATA. The read loop runs RD_REQ → RD_FILL → RD_DATA → RD_ACK. From RD_ACK a master ACK returns to RD_REQ and a master NACK goes to IGNORE.

Top module: `dual_addr_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) starts a new device byte from any state. A rising SDA while SCL is high (STOP) returns the block to IDLE, with SDA released from the next cycle.
- R2: Every byte travels MSB first. In the device byte, bits 7:1 hold the slave address and bit 0 is R/W (0 = write, 1 = read). A matching device byte is acknowledged by holding SDA low through the ninth SCL pulse.
- R3: Device bits 7:1 equal to 50h (byte A0h) select the auxiliary space (mem_sel = 0).
- R4: Device bits 7:1 equal to main_addr_cfg[7:1] select the main space (mem_sel = 1) only while main_addr_en is 1. With the enable at 0, that address is not acknowledged.
- R5: While main_addr_en is 1 and main_addr_cfg[7:1] is 50h, address A0h selects the main space and the auxiliary space cannot be reached.
- R6: If busy is 1 when the device byte ends, that byte is not acknowledged, even when it matches.
- R7: After a device byte that is not acknowledged, SDA stays released and no strobe is issued until the next START.
- R8: In a write, the byte after the device byte is loaded as the memory pointer and acknowledged. Each later byte is acknowledged and written with a single-cycle mem_we at the current pointer.
- R9: After each written byte, the pointer bits [2:0] step by one modulo 8 and bits [7:3] hold, so the write stays inside its 8-byte page.
- R10: A read returns bytes from the last captured pointer, MSB first. The pointer advances by one after each byte, modulo 256.
- R11: After the master NACKs a read byte, SDA stays released and no further read strobe is issued until the next START.
- R12: mem_re is a single-cycle pulse at mem_addr/mem_sel. mem_rdata is taken on the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| main_addr_cfg | input | 8 | Main-space device address (bits 7:1 used) |
| main_addr_en | input | 1 | Enables the main-space address |
| busy | input | 1 | Memory busy; refuses the device address |
| mem_sel | output | 1 | 0 auxiliary space, 1 main space |
| mem_addr | output | 8 | Memory pointer |
| mem_wdata | output | 8 | Write data, valid with mem_we |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_re | output | 1 | Single-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |

## Verification
The assertions check on every cycle that a START always reopens the device byte and a STOP always releases SDA. They also check that both strobes last exactly one cycle, that an address acknowledge never follows a busy sample, and that a page write never changes pointer bits 7:3. Only the bench's scenarios can show the behaviour seen from the bus. That covers which of the 128 addresses are acknowledged under each enable and configuration setting, and the byte order and pointer progression for page-wrapped writes and linear reads. It also covers the silence after a refused address or a final NACK, and the final contents of both spaces compared with arithmetic expectations.

// File: rtl/i2cms_pkg.sv
package i2cms_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV_ADDR,
        S_DEV_ACK,
        S_MEM_ADDR,
        S_MEM_ACK,
        S_WR_DATA,
        S_WR_COMMIT,
        S_WR_ACK,
        S_RD_REQ,
        S_RD_FILL,
        S_RD_DATA,
        S_RD_ACK,
        S_IGNORE
    } slv_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2cms_line_sync.sv
module i2cms_line_sync
    import i2cms_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] scl_p;
    logic [DEPTH-1:0] sda_p;
    logic scl_now, scl_old, sda_now, sda_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[DEPTH-2:0], scl_i};
            sda_p <= {sda_p[DEPTH-2:0], sda_i};
        end
    end

    assign scl_now = scl_p[DEPTH-2];
    assign scl_old = scl_p[DEPTH-1];
    assign sda_now = sda_p[DEPTH-2];
    assign sda_old = sda_p[DEPTH-1];

    always_comb begin
        evt.start    = scl_now & scl_old & sda_old & ~sda_now;
        evt.stop     = scl_now & scl_old & ~sda_old & sda_now;
        evt.scl_rise = scl_now & ~scl_old;
        evt.scl_fall = ~scl_now & scl_old;
        evt.sda      = sda_now;
    end

endmodule

// File: rtl/i2cms_addr_match.sv
module i2cms_addr_match #(
    parameter logic [7:0] AUX_ADDR = 8'hA0
) (
    input  logic [7:0] addr_byte,
    input  logic [7:0] cfg_addr,
    input  logic       cfg_en,
    input  logic       busy,
    output logic       hit,
    output logic       sel_main
);
    logic main_hit, aux_live, aux_hit;

    always_comb begin
        main_hit = cfg_en && (addr_byte[7:1] == cfg_addr[7:1]);
        aux_live = !(cfg_en && (cfg_addr[7:1] == AUX_ADDR[7:1]));
        aux_hit  = aux_live && (addr_byte[7:1] == AUX_ADDR[7:1]);
        hit      = (main_hit || aux_hit) && !busy;
        sel_main = main_hit;
    end

endmodule

// File: rtl/i2cms_addr_ptr.sv
module i2cms_addr_ptr #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_page,
    input  logic              step_lin,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << PAGE_BITS) - 1);

    logic [ADDR_W-1:0] ptr_inc;
    assign ptr_inc = ptr + ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step_page) begin
            ptr <= (ptr & ~LOW_MASK) | (ptr_inc & LOW_MASK);
        end else if (step_lin) begin
            ptr <= ptr_inc;
        end
    end

    // R9: a page step never leaves the current page
    assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_page && !load |=> ((ptr & ~LOW_MASK) == ($past(ptr) & ~LOW_MASK)));

endmodule

// File: rtl/dual_addr_i2c_slave.sv
module dual_addr_i2c_slave
    import i2cms_pkg::*;
#(
    parameter logic [7:0] AUX_ADDR    = 8'hA0,
    parameter int         PAGE_BITS   = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [7:0] main_addr_cfg,
    input  logic       main_addr_en,
    input  logic       busy,
    output logic       mem_sel,
    output logic [7:0] mem_addr,
    output logic [7:0] mem_wdata,
    output logic       mem_we,
    output logic       mem_re,
    input  logic [7:0] mem_rdata
);
    localparam int               CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(BYTE_W - 1);

    bus_evt_t          ev;
    slv_state_t        state, next;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              sel_q, rw_q, ack_seen;
    logic              hit, sel_main, byte_full, byte_end;
    logic              ptr_load, ptr_step_page, ptr_step_lin;

    i2cms_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (ev)
    );

    i2cms_addr_match #(.AUX_ADDR(AUX_ADDR)) u_match (
        .addr_byte (shreg),
        .cfg_addr  (main_addr_cfg),
        .cfg_en    (main_addr_en),
        .busy      (busy),
        .hit       (hit),
        .sel_main  (sel_main)
    );

    assign byte_full     = (bit_cnt == FULL);
    assign byte_end      = ev.scl_fall && byte_full;
    assign ptr_load      = (state == S_MEM_ADDR) && byte_end && !ev.start && !ev.stop;
    assign ptr_step_page = (state == S_WR_COMMIT);
    assign ptr_step_lin  = (state == S_RD_DATA) && ev.scl_fall && (bit_cnt == LAST)
                           && !ev.start && !ev.stop;

    i2cms_addr_ptr #(.ADDR_W(BYTE_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ptr_load),
        .load_val  (shreg),
        .step_page (ptr_step_page),
        .step_lin  (ptr_step_lin),
        .ptr       (mem_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= next;
    end

    // next-state logic
    always_comb begin
        next = state;
        if (ev.start) begin
            next = S_DEV_ADDR;
        end else if (ev.stop) begin
            next = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:      next = S_IDLE;
                S_DEV_ADDR:  if (byte_end) next = hit ? S_DEV_ACK : S_IGNORE;
                S_DEV_ACK:   if (ev.scl_fall) next = rw_q ? S_RD_REQ : S_MEM_ADDR;
                S_MEM_ADDR:  if (byte_end) next = S_MEM_ACK;
                S_MEM_ACK:   if (ev.scl_fall) next = S_WR_DATA;
                S_WR_DATA:   if (byte_end) next = S_WR_COMMIT;
                S_WR_COMMIT: next = S_WR_ACK;
                S_WR_ACK:    if (ev.scl_fall) next = S_WR_DATA;
                S_RD_REQ:    next = S_RD_FILL;
                S_RD_FILL:   next = S_RD_DATA;
                S_RD_DATA:   if (ev.scl_fall && bit_cnt == LAST) next = S_RD_ACK;
                S_RD_ACK:    if (ev.scl_fall) next = ack_seen ? S_RD_REQ : S_IGNORE;
                S_IGNORE:    next = S_IGNORE;
                default:     next = S_IDLE;
            endcase
        end
    end

    // byte shifter, bit counter and transaction flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            sel_q    <= 1'b0;
            rw_q     <= 1'b0;
            ack_seen <= 1'b0;
        end else if (ev.start || ev.stop) begin
            bit_cnt <= '0;
        end else begin
            unique case (state)
                S_DEV_ADDR, S_MEM_ADDR, S_WR_DATA: begin
                    if (ev.scl_rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        if (state == S_DEV_ADDR && hit) begin
                            sel_q <= sel_main;
                            rw_q  <= shreg[0];
                        end
                    end
                end
                S_RD_FILL: begin
                    shreg   <= mem_rdata;
                    bit_cnt <= '0;
                end
                S_RD_DATA: begin
                    if (ev.scl_fall) begin
                        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CNT_W'(1);
                    end
                end
                S_RD_ACK: begin
                    if (ev.scl_rise) ack_seen <= ~ev.sda;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        mem_we = 1'b0;
        mem_re = 1'b0;
        unique case (state)
            S_DEV_ACK, S_MEM_ACK, S_WR_ACK: sda_oe = 1'b1;
            S_WR_COMMIT: begin
                sda_oe = 1'b1;
                mem_we = 1'b1;
            end
            S_RD_REQ:  mem_re = 1'b1;
            S_RD_DATA: sda_oe = ~shreg[BYTE_W-1];
            default: ;
        endcase
    end

    assign mem_sel   = sel_q;
    assign mem_wdata = shreg;

    // R1: START always reopens the device byte
    assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start |=> (state == S_DEV_ADDR));

    // R1: STOP always ends in IDLE with SDA released
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.stop && !ev.start) |=> (state == S_IDLE && !sda_oe));

    // R6: an address acknowledge never follows a busy sample
    assert_busy_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEV_ACK && $past(state) == S_DEV_ADDR) |-> !$past(busy));

    // R8: the write strobe lasts exactly one cycle
    assert_we_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R12: the read strobe lasts exactly one cycle
    assert_re_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

endmodule

// File: tb/dual_addr_i2c_slave_test.sv
module dual_addr_i2c_slave_test;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic [7:0] cfg_addr = 8'h3C;
    logic cfg_en = 1'b0;
    logic sda_oe, mem_sel, mem_we, mem_re, sda_bus;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;

    always #2 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    dual_addr_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .main_addr_cfg(cfg_addr), .main_addr_en(cfg_en), .busy(busy),
        .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    logic [7:0] mod_aux [256];
    logic [7:0] mod_main[256];
    logic [7:0] want_aux [256];
    logic [7:0] want_main[256];
    logic [7:0] wbuf[8];
    int we_cnt, re_cnt, strobe_double;
    logic last_sel, prev_we, prev_re;
    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    // memory model behind the slave
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                mod_aux[i]  <= 8'(i) ^ 8'h5A;
                mod_main[i] <= 8'(i * 3);
            end
            mem_rdata <= 8'h00;
            we_cnt <= 0; re_cnt <= 0; strobe_double <= 0;
            last_sel <= 1'b0; prev_we <= 1'b0; prev_re <= 1'b0;
        end else begin
            if (mem_we) begin
                if (mem_sel) mod_main[mem_addr] <= mem_wdata;
                else         mod_aux[mem_addr]  <= mem_wdata;
                we_cnt <= we_cnt + 1;
                last_sel <= mem_sel;
            end
            if (mem_re) begin
                mem_rdata <= mem_sel ? mod_main[mem_addr] : mod_aux[mem_addr];
                re_cnt <= re_cnt + 1;
                last_sel <= mem_sel;
            end
            if ((mem_we && prev_we) || (mem_re && prev_re)) strobe_double <= strobe_double + 1;
            prev_we <= mem_we;
            prev_re <= mem_re;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int want);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, want);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = !b;
    endtask

    task automatic get_byte(input logic more, output logic [7:0] v);
        logic b;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            v = {v[6:0], b};
        end
        put_bit(!more);
    endtask

    function automatic logic to_main(input logic [7:0] dev);
        return cfg_en && (dev[7:1] == cfg_addr[7:1]);
    endfunction

    function automatic logic should_ack(input logic [7:0] dev);
        return to_main(dev) || (dev[7:1] == 7'h50 && !(cfg_en && cfg_addr[7:1] == 7'h50));
    endfunction

    task automatic i2c_write(input logic [7:0] dev, input logic [7:0] ma, input int n);
        logic a;
        logic m;
        logic [7:0] loc;
        m = to_main(dev);
        bus_start();
        put_byte({dev[7:1], 1'b0}, a);
        check(a, "R2 device ack on write", a, 1);
        put_byte(ma, a);
        check(a, "R8 memory address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            put_byte(wbuf[k], a);
            check(a, "R8 data byte ack", a, 1);
            loc = {ma[7:3], 3'(ma[2:0] + 3'(k))};
            if (m) want_main[loc] = wbuf[k];
            else   want_aux[loc]  = wbuf[k];
        end
        bus_stop();
        check(!sda_oe, "R1 SDA released after STOP", sda_oe, 0);
    endtask

    task automatic i2c_read(input logic [7:0] dev, input logic [7:0] ma, input int n);
        logic a;
        logic m;
        logic [7:0] v;
        logic [7:0] w;
        int re_mark;
        m = to_main(dev);
        bus_start();
        put_byte({dev[7:1], 1'b0}, a);
        check(a, "R2 device ack before read", a, 1);
        put_byte(ma, a);
        check(a, "R8 pointer ack before read", a, 1);
        bus_start();
        put_byte({dev[7:1], 1'b1}, a);
        check(a, "R1 R2 device ack after repeated START", a, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(k < n - 1, v);
            w = m ? want_main[8'(ma + 8'(k))] : want_aux[8'(ma + 8'(k))];
            check(v == w, "R10 read byte", v, w);
        end
        check(!sda_oe, "R11 SDA released after NACK", sda_oe, 0);
        re_mark = re_cnt;
        put_byte(8'hFF, a);
        check(!a, "R11 no drive after NACK", a, 0);
        check(re_cnt == re_mark, "R11 no read strobe after NACK", re_cnt, re_mark);
        check(last_sel == m, "R12 read strobe space", last_sel, m);
        bus_stop();
    endtask

    task automatic sweep(input string tag);
        logic a;
        logic e;
        for (int d = 0; d < 128; d++) begin
            e = should_ack({7'(d), 1'b0});
            bus_start();
            put_byte({7'(d), 1'b0}, a);
            bus_stop();
            check(a == e, tag, a, e);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic a;
        int we_mark;
        for (int i = 0; i < 256; i++) begin
            want_aux[i]  = 8'(i) ^ 8'h5A;
            want_main[i] = 8'(i * 3);
        end
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(!sda_oe && !mem_we && !mem_re, "R1 reset idle outputs",
              {sda_oe, mem_we, mem_re}, 0);

        // R3 R9: auxiliary write that wraps inside its page
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        i2c_write(8'hA0, 8'h06, 3);
        check(mod_aux[8'h06] == 8'h11, "R8 byte at 06h", mod_aux[8'h06], 8'h11);
        check(mod_aux[8'h07] == 8'h22, "R8 byte at 07h", mod_aux[8'h07], 8'h22);
        check(mod_aux[8'h00] == 8'h33, "R9 page wrap to 00h", mod_aux[8'h00], 8'h33);
        check(last_sel == 1'b0, "R3 auxiliary space selected", last_sel, 0);
        i2c_read(8'hA0, 8'h05, 4);

        // R4 R7: main address while disabled
        bus_start();
        put_byte(8'h3C, a);
        check(!a, "R4 disabled main address refused", a, 0);
        we_mark = we_cnt;
        put_byte(8'h12, a);
        check(!a, "R7 ignored byte not acked", a, 0);
        put_byte(8'h34, a);
        check(!a, "R7 ignored byte not acked", a, 0);
        check(we_cnt == we_mark, "R7 no write strobe while ignoring", we_cnt, we_mark);
        bus_stop();

        // R4 R9 R10: main space enabled
        cfg_en = 1'b1;
        for (int k = 0; k < 8; k++) wbuf[k] = 8'(k * 17 + 1);
        i2c_write(8'h3C, 8'h10, 8);
        check(last_sel == 1'b1, "R4 main space selected", last_sel, 1);
        for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'hC0 + k);
        i2c_write(8'h3C, 8'h1D, 5);
        i2c_read(8'h3C, 8'h0E, 6);

        // R6: busy refuses the address
        busy = 1'b1;
        bus_start();
        put_byte(8'hA0, a);
        bus_stop();
        check(!a, "R6 busy refuses address", a, 0);
        busy = 1'b0;
        bus_start();
        put_byte(8'hA0, a);
        bus_stop();
        check(a, "R6 address acked once idle", a, 1);

        // R5: main address configured onto A0h
        cfg_addr = 8'hA0;
        wbuf[0] = 8'h5E; wbuf[1] = 8'hE5;
        i2c_write(8'hA0, 8'h30, 2);
        check(last_sel == 1'b1, "R5 A0h selects main space", last_sel, 1);
        check(mod_main[8'h30] == 8'h5E, "R5 write landed in main", mod_main[8'h30], 8'h5E);
        check(mod_aux[8'h30] == want_aux[8'h30], "R5 auxiliary untouched",
              mod_aux[8'h30], want_aux[8'h30]);
        i2c_read(8'hA0, 8'h2F, 3);

        sweep("R5 address sweep with main on A0h");
        cfg_addr = 8'h3C;
        sweep("R3 R4 address sweep with main enabled");
        cfg_en = 1'b0;
        sweep("R4 address sweep with main disabled");

        check(strobe_double == 0, "R12 strobes single cycle", strobe_double, 0);
        for (int i = 0; i < 256; i++) begin
            check(mod_aux[i] == want_aux[i], "R8 auxiliary image", mod_aux[i], want_aux[i]);
            check(mod_main[i] == want_main[i], "R8 main image", mod_main[i], want_main[i]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule